// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single memory requests from a 16-bit core into bus cycles on a shared address/data bus. A request carries an address, a direction, a size (byte or word) and write data. Each bus cycle has an address phase, a data phase that can be stretched, and a closing phase. The address is put on the bus and marked by a strobe. A read or write strobe then frames the data. Byte-lane signals tell the memory which half of the bus is in use.

The width of each cycle comes from a two-bit configuration. It is either fixed at 8 or 16 bits, or it follows a width pin sampled during the address phase. On an 8-bit bus a word request becomes two byte cycles, low byte first. The data phase is stretched while the ready pin is low, up to a configured number of wait states. The address strobe can be a short latch pulse or an active-low valid level. The byte-lane pins can encode the lane with address bit 0 and a high-byte enable, or they can act as separate low and high write strobes.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: `cfg_width` = 2'b10 makes every cycle 16-bit, 2'b01 makes every cycle 8-bit, and 2'b11 takes the width from `bus_width_pin` sampled in the address phase (0 gives 8-bit, 1 gives 16-bit); `width_err` is low for these three codes.
- R2: `cfg_width` = 2'b00 is illegal: `width_err` is high and cycles run as 8-bit.
- R3: In the address phase `ad_out` carries the address, with bit 0 cleared for a word request. With `cfg_split_wr` = 0, `bhe_n` is 1 for an even byte, 0 for an odd byte and 0 for a word.
- R4: With `cfg_split_wr` = 1, `wr_n` goes low in a write data phase only if the cycle address is even. `bhe_n` goes low only in a write data phase whose address is odd, or in a 16-bit word write. Neither pin goes low in a read, and `rd_n` and `wr_n` are never low together.
- R5: The data phase lasts one clock plus one clock for each clock edge at which `ready_pin` is sampled low, as long as the cap is not reached. A high `ready_pin` sampled in the data phase ends it at that edge.
- R6: No more than `cfg_max_wait` wait states are added. If `ready_pin` stays low, the data phase lasts exactly `cfg_max_wait`+1 clocks and the cycle completes.
- R7: With `cfg_adv_mode` = 0, `addr_strobe` is high only during the one-clock address phase. With `cfg_adv_mode` = 1, it is low from the address phase through the data phase and high in the closing phase and when idle.
- R8: On an 8-bit bus a word request runs as two byte cycles: first at the even address, then at address+1. Each write byte is on `ad_out[7:0]`, low byte first. Read bytes are taken from `ad_in[7:0]` and assembled into `rd_data` with the low byte in bits 7:0.
- R9: On a 16-bit cycle a word uses all of `ad_in`/`ad_out`. A byte at an odd address uses bits 15:8 and a byte at an even address uses bits 7:0. A read byte is returned in `rd_data[7:0]` with `rd_data[15:8]` = 0.
- R10: A request is accepted only when `busy` is low and is latched when accepted; later changes on the request inputs have no effect. `done` is high for exactly one clock, in the closing phase of the last bus cycle, and `rd_data` is valid with it.
- R11: After reset `busy`, `done` and `ad_oe` are low, `rd_n`, `wr_n` and `bhe_n` are high, and `addr_strobe` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | AD_W | Byte address |
| req_wdata | input | AD_W | Write data (byte in bits 7:0) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | AD_W | Read result |
| cfg_width | input | 2 | Bus width selection code |
| cfg_split_wr | input | 1 | 1 = separate low/high write strobes |
| cfg_adv_mode | input | 1 | 1 = active-low valid strobe, 0 = latch pulse |
| cfg_max_wait | input | WAIT_W | Wait-state cap |
| width_err | output | 1 | Illegal width code |
| bus_width_pin | input | 1 | Per-cycle width from the bus |
| ready_pin | input | 1 | Memory ready |
| addr_strobe | output | 1 | Address latch / valid strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe or low-byte write strobe |
| bhe_n | output | 1 | High-byte enable or high-byte write strobe |
| ad_out | output | AD_W | Driven address/data |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | AD_W | Sampled address/data bus |

## Verification
A wrong phase register shows within one clock as a strobe at the wrong level or an extra address phase. Examples are a read strobe that never rises or a valid strobe that stays low through the closing phase. A corrupt wait counter shows within the same transfer as a data phase whose length differs from min(ready-low count, cap)+1. A stale width or half-select bit shows at `done` as one bus cycle too many or too few, bytes on the wrong lane, or a `rd_data` built in the wrong byte order. Near-exhaustive sweeps over width code, width pin, size, direction, address parity and wait pattern expose each of these in the transfer where it happens.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_END  = 2'd3
  } bus_ph_e;

  localparam logic [1:0] WSEL_BAD    = 2'b00;
  localparam logic [1:0] WSEL_NARROW = 2'b01;
  localparam logic [1:0] WSEL_WIDE   = 2'b10;
  localparam logic [1:0] WSEL_PIN    = 2'b11;

endpackage

// File: rtl/xbus_width_sel.sv
module xbus_width_sel
  import xbus_pkg::*;
(
  input  logic [1:0] cfg_width,
  input  logic       width_pin,
  output logic       wide,
  output logic       cfg_err
);

  always_comb begin
    wide    = 1'b0;
    cfg_err = 1'b0;
    unique case (cfg_width)
      WSEL_WIDE:   wide = 1'b1;
      WSEL_PIN:    wide = width_pin;
      WSEL_NARROW: wide = 1'b0;
      default:     cfg_err = 1'b1;
    endcase
  end

endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [WAIT_W-1:0] cap,
  output logic              at_cap
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign at_cap = (cnt_q == cap);
  assign cnt_en = clr | step;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/xbus_lane_map.sv
module xbus_lane_map
  import xbus_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  bus_ph_e         ph,
  input  logic            is_write,
  input  logic            is_word,
  input  logic            wide,
  input  logic            upper_part,
  input  logic            split_wr,
  input  logic            adv_mode,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  output logic            addr_strobe,
  output logic            rd_n,
  output logic            wr_n,
  output logic            bhe_n,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe
);

  localparam int LANE_W = AD_W / 2;
  localparam int LANES  = 2;

  logic              odd;
  logic              both_lanes;
  logic [LANE_W-1:0] byte_val;
  logic [AD_W-1:0]   data_drive;

  assign odd        = addr[0];
  assign both_lanes = is_word & wide;
  assign byte_val   = upper_part ? wdata[AD_W-1:LANE_W] : wdata[LANE_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_drive[g*LANE_W +: LANE_W] =
      both_lanes ? wdata[g*LANE_W +: LANE_W] : byte_val;
  end

  always_comb begin
    addr_strobe = adv_mode;
    rd_n        = 1'b1;
    wr_n        = 1'b1;
    bhe_n       = 1'b1;
    ad_out      = '0;
    ad_oe       = 1'b0;
    unique case (ph)
      PH_ADDR: begin
        addr_strobe = ~adv_mode;
        ad_out      = addr;
        ad_oe       = 1'b1;
        if (!split_wr) bhe_n = ~(odd | is_word);
      end
      PH_DATA: begin
        addr_strobe = 1'b0;
        if (is_write) begin
          ad_out = data_drive;
          ad_oe  = 1'b1;
          if (split_wr) begin
            wr_n  = odd;
            bhe_n = ~(odd | both_lanes);
          end else begin
            wr_n  = 1'b0;
            bhe_n = ~(odd | is_word);
          end
        end else begin
          rd_n = 1'b0;
          if (!split_wr) bhe_n = ~(odd | is_word);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int AD_W   = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              busy,
  output logic              done,
  output logic [AD_W-1:0]   rd_data,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_split_wr,
  input  logic              cfg_adv_mode,
  input  logic [WAIT_W-1:0] cfg_max_wait,
  output logic              width_err,
  input  logic              bus_width_pin,
  input  logic              ready_pin,
  output logic              addr_strobe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bhe_n,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in
);

  localparam int LANE_W = AD_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // transfer state
  bus_ph_e         ph_q, ph_d;
  logic [AD_W-1:0] addr_q, addr_d;
  logic [AD_W-1:0] wdata_q, wdata_d;
  logic [AD_W-1:0] rd_q, rd_d;
  logic            write_q, write_d;
  logic            word_q, word_d;
  logic            part_q, part_d;
  logic            wide_q, wide_d;

  logic            wide_now;
  logic            wt_clr, wt_step, wt_at_cap;
  logic            split_pending;
  logic [LANE_W-1:0] lane_byte;
  logic [AD_W-1:0]   rd_capture;

  xbus_width_sel u_width (
    .cfg_width (cfg_width),
    .width_pin (bus_width_pin),
    .wide      (wide_now),
    .cfg_err   (width_err)
  );

  xbus_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (wt_clr),
    .step   (wt_step),
    .cap    (cfg_max_wait),
    .at_cap (wt_at_cap)
  );

  xbus_lane_map #(.AD_W(AD_W)) u_lanes (
    .ph          (ph_q),
    .is_write    (write_q),
    .is_word     (word_q),
    .wide        (wide_q),
    .upper_part  (part_q),
    .split_wr    (cfg_split_wr),
    .adv_mode    (cfg_adv_mode),
    .addr        (addr_q),
    .wdata       (wdata_q),
    .addr_strobe (addr_strobe),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .bhe_n       (bhe_n),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe)
  );

  assign split_pending = word_q & ~wide_q;
  assign busy          = (ph_q != PH_IDLE);
  assign done          = (ph_q == PH_END) & ~split_pending;
  assign rd_data       = rd_q;

  // read lane steering
  always_comb begin
    lane_byte = (wide_q & addr_q[0]) ? ad_in[AD_W-1:LANE_W] : ad_in[LANE_W-1:0];
    if (word_q & wide_q) rd_capture = ad_in;
    else if (part_q)     rd_capture = {lane_byte, rd_q[LANE_W-1:0]};
    else                 rd_capture = {{LANE_W{1'b0}}, lane_byte};
  end

  // next state
  always_comb begin
    ph_d    = ph_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rd_d    = rd_q;
    write_d = write_q;
    word_d  = word_q;
    part_d  = part_q;
    wide_d  = wide_q;
    wt_clr  = 1'b0;
    wt_step = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_d    = PH_ADDR;
          addr_d  = req_word ? {req_addr[AD_W-1:1], 1'b0} : req_addr;
          wdata_d = req_wdata;
          write_d = req_write;
          word_d  = req_word;
          part_d  = 1'b0;
        end
      end
      PH_ADDR: begin
        ph_d   = PH_DATA;
        wide_d = wide_now;
        wt_clr = 1'b1;
      end
      PH_DATA: begin
        if (ready_pin || wt_at_cap) begin
          ph_d = PH_END;
          if (!write_q) rd_d = rd_capture;
        end else begin
          wt_step = 1'b1;
        end
      end
      PH_END: begin
        if (split_pending) begin
          ph_d   = PH_ADDR;
          part_d = 1'b1;
          word_d = 1'b0;
          addr_d = {addr_q[AD_W-1:1], 1'b1};
        end else begin
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      part_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
      write_q <= write_d;
      word_q  <= word_d;
      part_q  <= part_d;
      wide_q  <= wide_d;
    end
  end

endmodule

// File: rtl/xbus_cycle_ctrl_chk.sv
module xbus_cycle_ctrl_chk
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input bus_ph_e           ph,
  input logic              ready_pin,
  input logic [WAIT_W-1:0] cfg_max_wait,
  input logic              cfg_adv_mode,
  input logic              addr_strobe,
  input logic              rd_n,
  input logic              wr_n,
  input logic              done,
  input logic [1:0]        cfg_width,
  input logic              width_err
);

  logic [WAIT_W:0] dcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dcnt_q <= '0;
    else if (ph == PH_DATA)  dcnt_q <= dcnt_q + 1'b1;
    else                     dcnt_q <= '0;
  end

  assert_wait_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA) |-> (dcnt_q <= {1'b0, cfg_max_wait}));

  assert_ready_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && ready_pin) |=> (ph == PH_END));

  assert_valid_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_adv_mode && (ph == PH_IDLE || ph == PH_END)) |-> addr_strobe);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'b00) |-> width_err);

  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

endmodule

bind xbus_cycle_ctrl xbus_cycle_ctrl_chk #(.WAIT_W(WAIT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ph           (ph_q),
  .ready_pin    (ready_pin),
  .cfg_max_wait (cfg_max_wait),
  .cfg_adv_mode (cfg_adv_mode),
  .addr_strobe  (addr_strobe),
  .rd_n         (rd_n),
  .wr_n         (wr_n),
  .done         (done),
  .cfg_width    (cfg_width),
  .width_err    (width_err)
);

// File: tb/test_xbus_cycle_ctrl.sv
module test_xbus_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [15:0] req_addr, req_wdata;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [1:0]  cfg_width;
  logic        cfg_split_wr, cfg_adv_mode;
  logic [2:0]  cfg_max_wait;
  logic        width_err;
  logic        bus_width_pin;
  logic        ready_pin;
  logic        addr_strobe, rd_n, wr_n, bhe_n, ad_oe;
  logic [15:0] ad_out, ad_in;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench memory model state
  int          want = 0;
  bit          exp_wide = 1'b0;
  logic [15:0] la = '0;
  bit          prev_strobe = 1'b1;
  int          ncyc = 0, dk = 0, dtot = 0, dlen_last = 0, hi_cnt = 0, lo_cnt = 0;
  logic [15:0] caddr [2];
  logic        cbhe  [2];
  logic [15:0] cwd   [2];
  logic        cwrl  [2];
  logic        cwrh  [2];

  always #4 clk = ~clk;

  xbus_cycle_ctrl i_xbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .cfg_width(cfg_width), .cfg_split_wr(cfg_split_wr), .cfg_adv_mode(cfg_adv_mode),
    .cfg_max_wait(cfg_max_wait), .width_err(width_err),
    .bus_width_pin(bus_width_pin), .ready_pin(ready_pin),
    .addr_strobe(addr_strobe), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'd37 + 16'd11;
    return t[7:0] ^ a[15:8];
  endfunction

  assign ad_in = exp_wide ? {mem(la | 16'h0001), mem(la & 16'hFFFE)} : {8'hEE, mem(la)};

  // bus-side monitor and ready generator
  always @(negedge clk) begin
    bit a_ph, d_ph;
    if (!rst_n) begin
      ready_pin   = 1'b1;
      prev_strobe = 1'b1;
    end else begin
      a_ph = cfg_adv_mode ? (!addr_strobe && prev_strobe) : addr_strobe;
      prev_strobe = addr_strobe;
      if (addr_strobe) hi_cnt++; else lo_cnt++;
      if (a_ph) begin
        la = ad_out;
        if (ncyc < 2) begin
          caddr[ncyc] = ad_out;
          cbhe[ncyc]  = bhe_n;
        end
        ncyc++;
        dk = 0;
      end
      d_ph = !rd_n || !wr_n || (cfg_split_wr && !bhe_n);
      if (d_ph) begin
        dk++;
        dtot++;
        if (dk == 1 && ncyc >= 1 && ncyc <= 2) begin
          cwd[ncyc-1]  = ad_out;
          cwrl[ncyc-1] = !wr_n;
          cwrh[ncyc-1] = !bhe_n;
        end
        dlen_last = dk;
        ready_pin = (dk > want);
      end else begin
        ready_pin = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] wcfg, input bit pin, input bit word, input bit wr,
                     input logic [15:0] addr, input logic [15:0] wd, input bit split,
                     input bit adv, input int maxw, input int want_w, input bit scramble);
    logic [15:0] ae, ca, exp_rd;
    int          encyc, exp_len, t;
    bit          ew;
    cfg_width     = wcfg;
    bus_width_pin = pin;
    cfg_split_wr  = split;
    cfg_adv_mode  = adv;
    cfg_max_wait  = 3'(maxw);
    want          = want_w;
    ew            = (wcfg == 2'b10) || (wcfg == 2'b11 && pin);
    exp_wide      = ew;
    @(negedge clk);
    #1;
    ncyc = 0; dtot = 0; dlen_last = 0; hi_cnt = 0; lo_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    if (scramble) begin
      req_addr = ~addr; req_wdata = ~wd; req_word = !word; req_write = !wr;
    end else begin
      req_valid = 1'b0;
    end
    t = 0;
    do begin
      @(negedge clk);
      #1;
      t++;
    end while (!done && t < 100);
    chk(done == 1'b1, "R10 done seen", {31'd0, done}, 32'd1);

    ae      = word ? {addr[15:1], 1'b0} : addr;
    encyc   = (word && !ew) ? 2 : 1;
    exp_len = ((want_w < maxw) ? want_w : maxw) + 1;
    exp_rd  = word ? {mem(ae | 16'h1), mem(ae)} : {8'h00, mem(ae)};

    chk(ncyc == encyc, (word && !ew) ? "R8 two byte cycles" : "R1 cycle count", ncyc, encyc);
    chk(width_err == (wcfg == 2'b00), "R2 width_err", {31'd0, width_err}, {31'd0, wcfg == 2'b00});
    chk(caddr[0] == ae, "R3 address phase", caddr[0], ae);
    if (encyc == 2) chk(caddr[1] == (ae | 16'h1), "R8 second address", caddr[1], ae | 16'h1);
    if (!split) chk(cbhe[0] == !(word || ae[0]), "R3 bhe_n", {31'd0, cbhe[0]}, {31'd0, !(word || ae[0])});
    chk(dlen_last == exp_len, (want_w > maxw) ? "R6 wait cap" : "R5 wait length", dlen_last, exp_len);
    if (adv) begin
      chk(lo_cnt == encyc + dtot, "R7 valid strobe low span", lo_cnt, encyc + dtot);
      chk(addr_strobe == 1'b1, "R7 valid strobe high at end", {31'd0, addr_strobe}, 32'd1);
    end else begin
      chk(hi_cnt == encyc, "R7 latch pulse count", hi_cnt, encyc);
    end
    if (!wr) begin
      chk(rd_data == exp_rd, ew ? "R9 read data" : "R8 read data", rd_data, exp_rd);
    end else begin
      for (int i = 0; i < encyc; i++) begin
        ca = (i == 0) ? ae : (ae | 16'h1);
        if (word && ew)
          chk(cwd[0] == wd, "R9 word write lanes", cwd[0], wd);
        else if (ew)
          chk((ae[0] ? cwd[0][15:8] : cwd[0][7:0]) == wd[7:0], "R9 byte write lane",
              ae[0] ? cwd[0][15:8] : cwd[0][7:0], wd[7:0]);
        else
          chk(cwd[i][7:0] == wd[8*i +: 8], "R8 narrow write byte", cwd[i][7:0], wd[8*i +: 8]);
        if (split) begin
          chk(cwrl[i] == !ca[0], "R4 low write strobe", {31'd0, cwrl[i]}, {31'd0, !ca[0]});
          chk(cwrh[i] == (ca[0] || (word && ew)), "R4 high write strobe",
              {31'd0, cwrh[i]}, {31'd0, ca[0] || (word && ew)});
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(!done && !busy, "R10 single done, idle after", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0;
    cfg_width = 2'b10; cfg_split_wr = 1'b0; cfg_adv_mode = 1'b0; cfg_max_wait = 3'd0;
    bus_width_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !done && !ad_oe, "R11 reset idle", {29'd0, busy, done, ad_oe}, 32'd0);
    chk(rd_n && wr_n && bhe_n && !addr_strobe, "R11 reset strobes",
        {28'd0, rd_n, wr_n, bhe_n, addr_strobe}, 32'he);

    // width code / pin / size / direction / parity sweep
    for (int wc = 0; wc < 4; wc++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 2; d++)
            for (int a0 = 0; a0 < 2; a0++)
              txn(2'(wc), p[0], w[0], d[0], 16'h3A50 + 16'(wc * 8 + p * 4) + 16'(a0),
                  16'hC3A5 ^ 16'(wc * 16 + d), 1'b0, 1'b0, 0, 0, 1'b0);

    // wait-state sweep against the cap
    for (int mw = 0; mw < 4; mw++)
      for (int ww = 0; ww < 6; ww++)
        txn(2'b10, 1'b0, 1'b0, 1'b0, 16'h0100 + 16'(mw * 6 + ww), 16'h0, 1'b0, 1'b0, mw, ww, 1'b0);
    txn(2'b01, 1'b0, 1'b1, 1'b1, 16'h0442, 16'h9D2E, 1'b0, 1'b0, 7, 3, 1'b0);

    // separate write strobes
    for (int wc = 1; wc < 3; wc++)
      for (int w = 0; w < 2; w++)
        for (int a0 = 0; a0 < 2; a0++)
          txn(2'(wc), 1'b0, w[0], 1'b1, 16'h2230 + 16'(a0), 16'h5B7C, 1'b1, 1'b0, 2, 1, 1'b0);
    txn(2'b10, 1'b0, 1'b1, 1'b0, 16'h2240, 16'h0, 1'b1, 1'b0, 0, 0, 1'b0);

    // valid-level strobe mode
    txn(2'b10, 1'b0, 1'b1, 1'b0, 16'h7780, 16'h0, 1'b0, 1'b1, 2, 2, 1'b0);
    txn(2'b01, 1'b0, 1'b1, 1'b1, 16'h7791, 16'hA1B2, 1'b0, 1'b1, 1, 0, 1'b0);
    txn(2'b11, 1'b1, 1'b0, 1'b0, 16'h77A3, 16'h0, 1'b0, 1'b1, 3, 5, 1'b0);

    // request inputs changing while busy are ignored
    txn(2'b01, 1'b0, 1'b1, 1'b0, 16'h5A5A, 16'h0, 1'b0, 1'b0, 1, 1, 1'b1);
    txn(2'b10, 1'b0, 1'b0, 1'b1, 16'h1235, 16'h00C7, 1'b0, 1'b0, 0, 0, 1'b1);

    summary();
    $finish;
  end

endmodule